// File: doc/BRIEF.md
# DAC Calibration Datapath

This block keeps the per-channel calibration state of an eight-channel DAC and turns each host write into the 12-bit data word for that channel's DAC latch. Every channel has three stored words: the sample code, an unsigned gain trim and a signed zero trim. When correction is enabled, the block recomputes the channel's output whenever any of its three words is written. The result is the sample scaled by (gain + 2048)/4096, with the low 12 bits of the product dropped. The signed zero trim is then added and the sum is clamped to 0..4095. When correction is disabled, a sample write goes to the output exactly as written. Gain and zero writes are then only stored.

Writes enter on a valid/ready port and results leave on a valid/ready port with a single register stage between them. A write is taken in a cycle where `wr_valid` and `wr_ready` are both high. `wr_ready` is high when the output stage is empty, or when its word is being taken in the same cycle. So a stalled consumer (`out_ready` low) stops new writes after one word is held. A held output word and its channel number stay unchanged until they are taken. A strap selects whether sample codes are straight binary or two's complement. Any word can be read back at once through a separate combinational read port.

Top module: `dac_cal_core`

## Requirements
- R1: After reset, every channel reads back sample 000h, gain 800h (2048, unity) and zero 000h. `out_valid` is low.
- R2: With `corr_en` high, the output for a channel is floor(S × (G + 2048) / 4096) + Z. S is the sample as offset binary, G is the unsigned gain (0..4095, giving a factor from 0.5 to about 1.5) and Z is the two's-complement zero trim (−2048..+2047).
- R3: A corrected result below 0 is output as 000h and a result above 4095 is output as FFFh; it never wraps.
- R4: With `fmt_twos` high, a sample is read as two's complement. Its MSB is inverted before scaling, so 000h means midscale, 800h means the lowest code and 7FFh means the highest code. Gain and zero words are interpreted the same way regardless of `fmt_twos`.
- R5: With `corr_en` high, an accepted write to the sample, gain or zero word of a channel yields exactly one output word for that channel. The output uses the new value together with the channel's other two stored words.
- R6: With `corr_en` low, an accepted sample write outputs the written code unchanged. An accepted gain or zero write is stored and yields no output word.
- R7: Read-back returns the last accepted value of the selected word exactly as it was written (`rd_sel`: 0 sample, 1 gain, 2 zero).
- R8: While `out_valid` is high and `out_ready` is low, `out_data` and `out_chan` hold and `wr_ready` is low. A write offered during the stall is not stored.
- R9: `out_chan` carries the channel number of the write that produced the word.
- R10: A write with `wr_sel` = 3 stores nothing and yields no output word. Read-back with `rd_sel` = 3 returns 000h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| corr_en | input | 1 | 1: apply gain/zero correction; 0: pass samples through |
| fmt_twos | input | 1 | Sample format strap: 0 straight binary, 1 two's complement |
| wr_valid | input | 1 | Write offered |
| wr_ready | output | 1 | Write can be taken this cycle |
| wr_chan | input | 3 | Channel addressed by the write |
| wr_sel | input | 2 | Target word: 0 sample, 1 gain, 2 zero, 3 none |
| wr_data | input | 12 | Write value |
| rd_chan | input | 3 | Read-back channel |
| rd_sel | input | 2 | Read-back word, same encoding as `wr_sel` |
| rd_data | output | 12 | Read-back value (combinational) |
| out_valid | output | 1 | DAC data word available |
| out_ready | input | 1 | Consumer takes the word this cycle |
| out_chan | output | 3 | Channel of the DAC data word |
| out_data | output | 12 | DAC data word |

## Verification
The bound checker watches the handshake rules on every cycle. It checks that a stalled word and its channel hold and that writes are refused during a stall. It also checks that each accepted write produces an output, or produces none, according to the mode and the target word. The pass-through value, the channel tag and the read-back of the last accepted write are checked on every cycle as well. The arithmetic (truncation of the scaled product, clamping at both ends and the two's-complement sample conversion) can only be shown by the bench's vectors with hand-derived results. The same holds for the reset defaults and for gain and zero values written while correction was off and used only after it is turned on.

// File: rtl/dac_cal_pkg.sv
package dac_cal_pkg;

  typedef enum logic [1:0] {
    TGT_SAMPLE = 2'd0,
    TGT_GAIN   = 2'd1,
    TGT_ZERO   = 2'd2,
    TGT_NONE   = 2'd3
  } target_e;

  // Gain word that gives a scale factor of exactly one.
  function automatic int unsigned unity_gain(input int unsigned dw);
    return 1 << (dw - 1);
  endfunction

endpackage

// File: rtl/dac_cal_regbank.sv
module dac_cal_regbank
  import dac_cal_pkg::*;
#(
  parameter  int NCH  = 8,
  parameter  int DW   = 12,
  localparam int CH_W = $clog2(NCH)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            we,
  input  logic [CH_W-1:0] wchan,
  input  logic [1:0]      wsel,
  input  logic [DW-1:0]   wdata,
  output logic [DW-1:0]   cur_sample,
  output logic [DW-1:0]   cur_gain,
  output logic [DW-1:0]   cur_zero,
  input  logic [CH_W-1:0] rchan,
  input  logic [1:0]      rsel,
  output logic [DW-1:0]   rdata
);

  localparam logic [DW-1:0] GAIN_RST = DW'(unity_gain(DW));

  logic [DW-1:0] smp_a  [NCH];
  logic [DW-1:0] gain_a [NCH];
  logic [DW-1:0] zero_a [NCH];

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic          hit;
    logic [DW-1:0] smp_r, gain_r, zero_r;

    assign hit = we && (wchan == CH_W'(c));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        smp_r  <= '0;
        gain_r <= GAIN_RST;
        zero_r <= '0;
      end else if (hit) begin
        case (target_e'(wsel))
          TGT_SAMPLE: smp_r  <= wdata;
          TGT_GAIN:   gain_r <= wdata;
          TGT_ZERO:   zero_r <= wdata;
          default:    ;
        endcase
      end
    end

    assign smp_a[c]  = smp_r;
    assign gain_a[c] = gain_r;
    assign zero_a[c] = zero_r;
  end

  assign cur_sample = smp_a[wchan];
  assign cur_gain   = gain_a[wchan];
  assign cur_zero   = zero_a[wchan];

  always_comb begin
    case (target_e'(rsel))
      TGT_SAMPLE: rdata = smp_a[rchan];
      TGT_GAIN:   rdata = gain_a[rchan];
      TGT_ZERO:   rdata = zero_a[rchan];
      default:    rdata = '0;
    endcase
  end

endmodule

// File: rtl/dac_cal_math.sv
module dac_cal_math
  import dac_cal_pkg::*;
#(
  parameter int DW = 12
) (
  input  logic          twos,
  input  logic [DW-1:0] sample,
  input  logic [DW-1:0] gain,
  input  logic [DW-1:0] zero,
  output logic [DW-1:0] result
);

  localparam int GW = DW + 1;   // gain plus unity offset
  localparam int PW = DW + GW;  // full product
  localparam int SW = GW + 1;   // signed sum

  logic [DW-1:0]        offs;
  logic [GW-1:0]        factor;
  logic [PW-1:0]        prod;
  logic [GW-1:0]        scaled;
  logic signed [SW-1:0] sum;

  assign offs   = twos ? {~sample[DW-1], sample[DW-2:0]} : sample;
  assign factor = {1'b0, gain} + GW'(unity_gain(DW));
  assign prod   = PW'(offs) * PW'(factor);
  assign scaled = prod[PW-1:DW];
  assign sum    = $signed({1'b0, scaled}) +
                  $signed({{(SW-DW){zero[DW-1]}}, zero});

  always_comb begin
    if (sum[SW-1])       result = '0;
    else if (sum[SW-2])  result = '1;
    else                 result = sum[DW-1:0];
  end

endmodule

// File: rtl/dac_cal_outreg.sv
module dac_cal_outreg #(
  parameter  int NCH  = 8,
  parameter  int DW   = 12,
  localparam int CH_W = $clog2(NCH)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [CH_W-1:0] load_chan,
  input  logic [DW-1:0]   load_data,
  output logic            can_load,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [CH_W-1:0] out_chan,
  output logic [DW-1:0]   out_data
);

  assign can_load = !out_valid || out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_chan  <= '0;
      out_data  <= '0;
    end else if (can_load) begin
      out_valid <= load;
      if (load) begin
        out_chan <= load_chan;
        out_data <= load_data;
      end
    end
  end

endmodule

// File: rtl/dac_cal_core.sv
module dac_cal_core
  import dac_cal_pkg::*;
#(
  parameter  int NCH  = 8,
  parameter  int DW   = 12,
  localparam int CH_W = $clog2(NCH)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            corr_en,
  input  logic            fmt_twos,
  input  logic            wr_valid,
  output logic            wr_ready,
  input  logic [CH_W-1:0] wr_chan,
  input  logic [1:0]      wr_sel,
  input  logic [DW-1:0]   wr_data,
  input  logic [CH_W-1:0] rd_chan,
  input  logic [1:0]      rd_sel,
  output logic [DW-1:0]   rd_data,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [CH_W-1:0] out_chan,
  output logic [DW-1:0]   out_data
);

  logic          accept, produce;
  logic          is_smp, is_trim;
  logic [DW-1:0] cur_smp, cur_gain, cur_zero;
  logic [DW-1:0] eff_smp, eff_gain, eff_zero;
  logic [DW-1:0] corrected, next_word;

  assign accept  = wr_valid && wr_ready;
  assign is_smp  = (wr_sel == TGT_SAMPLE);
  assign is_trim = (wr_sel == TGT_GAIN) || (wr_sel == TGT_ZERO);
  assign produce = accept && (is_smp || (corr_en && is_trim));

  dac_cal_regbank #(.NCH(NCH), .DW(DW)) i_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .we         (accept),
    .wchan      (wr_chan),
    .wsel       (wr_sel),
    .wdata      (wr_data),
    .cur_sample (cur_smp),
    .cur_gain   (cur_gain),
    .cur_zero   (cur_zero),
    .rchan      (rd_chan),
    .rsel       (rd_sel),
    .rdata      (rd_data)
  );

  // Fold the incoming word over the stored one so the result uses it now.
  assign eff_smp  = is_smp                  ? wr_data : cur_smp;
  assign eff_gain = (wr_sel == TGT_GAIN)    ? wr_data : cur_gain;
  assign eff_zero = (wr_sel == TGT_ZERO)    ? wr_data : cur_zero;

  dac_cal_math #(.DW(DW)) i_math (
    .twos   (fmt_twos),
    .sample (eff_smp),
    .gain   (eff_gain),
    .zero   (eff_zero),
    .result (corrected)
  );

  assign next_word = corr_en ? corrected : wr_data;

  dac_cal_outreg #(.NCH(NCH), .DW(DW)) i_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (produce),
    .load_chan (wr_chan),
    .load_data (next_word),
    .can_load  (wr_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_chan  (out_chan),
    .out_data  (out_data)
  );

endmodule

// File: rtl/dac_cal_core_chk.sv
module dac_cal_core_chk #(
  parameter  int NCH  = 8,
  parameter  int DW   = 12,
  localparam int CH_W = $clog2(NCH)
) (
  input logic            clk,
  input logic            rst_n,
  input logic            corr_en,
  input logic            fmt_twos,
  input logic            wr_valid,
  input logic            wr_ready,
  input logic [CH_W-1:0] wr_chan,
  input logic [1:0]      wr_sel,
  input logic [DW-1:0]   wr_data,
  input logic [CH_W-1:0] rd_chan,
  input logic [1:0]      rd_sel,
  input logic [DW-1:0]   rd_data,
  input logic            out_valid,
  input logic            out_ready,
  input logic [CH_W-1:0] out_chan,
  input logic [DW-1:0]   out_data
);

  logic acc;
  assign acc = wr_valid && wr_ready;

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_chan)));

  p_stall_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !wr_ready);

  p_recalc_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && corr_en && wr_sel != 2'd3) |=> out_valid);

  p_bypass_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !corr_en && wr_sel == 2'd0) |=> (out_valid && out_data == $past(wr_data)));

  p_silent_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && (wr_sel == 2'd3 || (!corr_en && wr_sel != 2'd0))) |=> !out_valid);

  p_chan_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && wr_sel == 2'd0) |=> (out_chan == $past(wr_chan)));

  p_readback_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && wr_sel != 2'd3) |=>
      (rd_chan != $past(wr_chan) || rd_sel != $past(wr_sel) || rd_data == $past(wr_data)));

endmodule

bind dac_cal_core dac_cal_core_chk #(.NCH(NCH), .DW(DW)) i_chk (.*);

// File: tb/test_dac_cal_core.sv
module test_dac_cal_core;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        corr_en = 1'b0, fmt_twos = 1'b0;
  logic        wr_valid = 1'b0, wr_ready;
  logic [2:0]  wr_chan = '0;
  logic [1:0]  wr_sel = '0;
  logic [11:0] wr_data = '0;
  logic [2:0]  rd_chan = '0;
  logic [1:0]  rd_sel = '0;
  logic [11:0] rd_data;
  logic        out_valid, out_ready = 1'b1;
  logic [2:0]  out_chan;
  logic [11:0] out_data;

  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  dac_cal_core i_dac_cal_core (.*);

  task automatic check(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_write(input bit en, input bit fmt, input int ch,
                          input int sel, input int data);
    @(negedge clk);
    corr_en = en; fmt_twos = fmt;
    wr_chan = 3'(ch); wr_sel = 2'(sel); wr_data = 12'(data);
    wr_valid = 1'b1;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic readback(input int ch, input int sel, input int exp, input string req);
    rd_chan = 3'(ch); rd_sel = 2'(sel);
    #1;
    check(req, int'(rd_data), exp);
  endtask

  // {en, fmt, chan[3], sel[2], data[12], exp_valid, exp_data[12]}
  localparam int NV = 17;
  localparam logic [31:0] VEC [NV] = '{
    {1'b1,1'b0,3'd0,2'd0,12'h800,1'b1,12'h800},  // R2 unity
    {1'b1,1'b0,3'd0,2'd1,12'hFFF,1'b1,12'hBFF},  // R5 gain write, truncation
    {1'b1,1'b0,3'd0,2'd2,12'h064,1'b1,12'hC63},  // R5 zero +100
    {1'b1,1'b0,3'd0,2'd0,12'hFFF,1'b1,12'hFFF},  // R3 clamp high
    {1'b1,1'b0,3'd1,2'd2,12'h800,1'b1,12'h000},  // R3 clamp low
    {1'b1,1'b0,3'd1,2'd1,12'h000,1'b1,12'h000},  // R2 gain 0.5
    {1'b1,1'b0,3'd1,2'd0,12'hFFF,1'b1,12'h000},  // R3 2047-2048
    {1'b1,1'b0,3'd1,2'd2,12'h000,1'b1,12'h7FF},  // R2 half scale
    {1'b1,1'b1,3'd2,2'd0,12'h000,1'b1,12'h800},  // R4 midscale
    {1'b1,1'b1,3'd2,2'd0,12'h800,1'b1,12'h000},  // R4 most negative
    {1'b1,1'b1,3'd2,2'd0,12'h7FF,1'b1,12'hFFF},  // R4 most positive
    {1'b0,1'b0,3'd3,2'd0,12'h123,1'b1,12'h123},  // R6 pass
    {1'b0,1'b0,3'd3,2'd1,12'h000,1'b0,12'h000},  // R6 gain silent
    {1'b0,1'b0,3'd3,2'd2,12'h7FF,1'b0,12'h000},  // R6 zero silent
    {1'b0,1'b1,3'd4,2'd0,12'h800,1'b1,12'h800},  // R6 pass as written
    {1'b1,1'b0,3'd3,2'd0,12'h123,1'b1,12'h890},  // R5 uses stored trims
    {1'b1,1'b0,3'd7,2'd0,12'h400,1'b1,12'h400}   // R9 last channel
  };

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 out_valid", int'(out_valid), 0);
    for (int c = 0; c < 8; c++) begin
      readback(c, 0, 12'h000, "R1 sample");
      readback(c, 1, 12'h800, "R1 gain");
      readback(c, 2, 12'h000, "R1 zero");
    end
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      logic [31:0] v;
      v = VEC[i];
      do_write(v[31], v[30], int'(v[29:27]), int'(v[26:25]), int'(v[24:13]));
      check($sformatf("R2-vec%0d valid", i), int'(out_valid), int'(v[12]));
      if (v[12]) begin
        check($sformatf("R2 R3 R4 vec%0d data", i), int'(out_data), int'(v[11:0]));
        check($sformatf("R9 vec%0d chan", i), int'(out_chan), int'(v[29:27]));
      end
    end

    // R7 read-back as written
    readback(1, 1, 12'h000, "R7 gain");
    readback(2, 0, 12'h7FF, "R7 sample twos");
    readback(3, 2, 12'h7FF, "R7 zero");
    readback(0, 1, 12'hFFF, "R7 gain ch0");

    // R10 reserved target
    do_write(1'b1, 1'b0, 6, 3, 12'hABC);
    check("R10 no output", int'(out_valid), 0);
    readback(6, 0, 12'h000, "R10 sample");
    readback(6, 1, 12'h800, "R10 gain");
    readback(6, 2, 12'h000, "R10 zero");
    readback(6, 3, 12'h000, "R10 rd none");

    // R8 back-pressure
    out_ready = 1'b0;
    do_write(1'b1, 1'b0, 5, 0, 12'h555);
    check("R8 held valid", int'(out_valid), 1);
    check("R8 wr_ready low", int'(wr_ready), 0);
    wr_chan = 3'd5; wr_sel = 2'd0; wr_data = 12'h111; wr_valid = 1'b1;
    @(negedge clk);
    check("R8 data held", int'(out_data), 12'h555);
    check("R8 chan held", int'(out_chan), 5);
    readback(5, 0, 12'h555, "R8 stalled write not stored");
    out_ready = 1'b1;
    @(negedge clk);
    wr_valid = 1'b0;
    check("R8 next word valid", int'(out_valid), 1);
    check("R8 next word", int'(out_data), 12'h111);
    @(negedge clk);
    check("R8 drained", int'(out_valid), 0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule